// File: doc/BRIEF.md
# Rotating-Permutation Block Scheduler

This block sits in front of a square fabric that connects NP data sources to NP data destinations. A source hands the block one fragment at a time, given as a byte length, a destination port and an event number. The block cuts each fragment into blocks of one fixed byte size and releases the blocks in time slots of constant length. Slot k lets source i address only destination (i + k) mod NP, and the slot index steps by one after every slot period. As a result, no two sources ever target the same destination in the same slot, and the fabric cannot congest.

A source whose fragment is bound for a destination other than its current one stays idle in that slot and keeps the schedule. It therefore gets one block out per full rotation of NP slots. Each block leaves as a one-cycle descriptor. The descriptor carries the destination, a reassembly tag (event number, source number, block sequence number, final-block flag) and the count of valid bytes. A final block is padded to the full block size, and its descriptor reports the true remainder.

Top module: `bsh_top`

## Requirements
- R1: While reset is high and in the first cycle after it, every `frag_ready_o` bit is 1, no `blk_valid_o` bit is set and `slot_o` is 0.
- R2: A slot lasts SLOT_CYC = BLOCK_BYTES / LINK_BYTES cycles (8 by default). Counting cycles n = 1, 2, … after reset falls, `slot_o` equals (n / SLOT_CYC) mod NP, and a block descriptor is only ever valid in a cycle where n mod SLOT_CYC = 1.
- R3: A valid descriptor from source i carries `blk_dest_o[i]` = (i + `slot_o`) mod NP.
- R4: No two descriptors that are valid in the same cycle carry the same destination.
- R5: A fragment of L bytes yields exactly ceil(L / BLOCK_BYTES) blocks, with sequence numbers 0, 1, 2, … in order. The destination given at load is used for all of them.
- R6: Every non-final block reports BLOCK_BYTES bytes with the final flag 0. The final block reports L − (blocks − 1)·BLOCK_BYTES bytes, in the range 1..BLOCK_BYTES, with the final flag 1.
- R7: Every block carries the event number given at load and the number of the source it came from.
- R8: A source that holds a fragment whose destination is not its current one emits nothing. Consecutive blocks of one fragment are exactly NP slots apart.
- R9: A request with nonzero length, presented while `frag_ready_o[i]` is 1, is taken at the next edge, and ready drops to 0. A request presented while ready is 0 is ignored. Ready is 1 again in the cycle the final block's descriptor is valid.
- R10: A request with length 0 is ignored: ready stays 1 and no block is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frag_valid_i | input | NP | Per-source fragment request |
| frag_len_i | input | NP×LENW | Per-source fragment length in bytes |
| frag_dest_i | input | NP×PW | Per-source destination port |
| frag_evid_i | input | NP×EVW | Per-source event number |
| frag_ready_o | output | NP | Source can accept a new fragment |
| blk_valid_o | output | NP | Block descriptor valid, per source |
| blk_dest_o | output | NP×PW | Destination of the block |
| blk_evid_o | output | NP×EVW | Tag: event number |
| blk_src_o | output | NP×PW | Tag: source number |
| blk_seq_o | output | NP×SEQW | Tag: block sequence number |
| blk_last_o | output | NP | Tag: final block of the fragment |
| blk_bytes_o | output | NP×BCW | Valid bytes in the block |
| slot_o | output | PW | Current slot index |

## Verification
The assertions check the cycle-level rules on every cycle: the slot index moves only at a period boundary, descriptors appear only in the phase after launch, each one follows the rotation, no two share a destination, and padding and byte counts stay within their bounds. Load and zero-length handling at each source's ready line are checked the same way. Only the bench's scenarios can show that a fragment is cut into the right number of blocks, with the right sequence and remainder, with its own event number and with no extra blocks. The same holds for the spacing of a full rotation between blocks and for ignoring a request that arrives while the source is busy.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    localparam int NP          = 8;
    localparam int BLOCK_BYTES = 64;
    localparam int LINK_BYTES  = 8;
    localparam int LENW        = 16;
    localparam int EVW         = 8;

    localparam int PW       = (NP > 1) ? $clog2(NP) : 1;
    localparam int SLOT_CYC = BLOCK_BYTES / LINK_BYTES;
    localparam int CW       = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam int BSH      = $clog2(BLOCK_BYTES);
    localparam int SEQW     = LENW - BSH;
    localparam int BCW      = $clog2(BLOCK_BYTES + 1);
    localparam int PHASE1   = (SLOT_CYC > 1) ? 1 : 0;

    typedef logic [PW-1:0]   port_t;
    typedef logic [CW-1:0]   cyc_t;
    typedef logic [LENW-1:0] len_t;
    typedef logic [EVW-1:0]  evid_t;
    typedef logic [SEQW-1:0] seq_t;
    typedef logic [BCW-1:0]  bcnt_t;

    typedef struct packed {
        evid_t evid;
        port_t src;
        seq_t  seq;
        logic  last;
    } tag_t;

    typedef struct packed {
        logic  valid;
        port_t dest;
        tag_t  tag;
        bcnt_t bytes;
    } blk_t;

    function automatic port_t dest_for(input int src, input int slot);
        return port_t'((src + slot) % NP);
    endfunction

endpackage

// File: rtl/bsh_slot_timer.sv
module bsh_slot_timer
    import bsh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output cyc_t  cyc_o,
    output port_t slot_o,
    output logic  launch_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_o  <= '0;
            slot_o <= '0;
        end else if (cyc_o == cyc_t'(SLOT_CYC - 1)) begin
            cyc_o  <= '0;
            slot_o <= (slot_o == port_t'(NP - 1)) ? '0 : slot_o + 1'b1;
        end else begin
            cyc_o <= cyc_o + 1'b1;
        end
    end

    assign launch_o = (cyc_o == '0);

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(cyc_o) != cyc_t'(SLOT_CYC - 1)) |-> $stable(slot_o)); // R2

endmodule

// File: rtl/bsh_lane.sv
module bsh_lane
    import bsh_pkg::*;
#(
    parameter int SRC = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  launch_i,
    input  port_t slot_i,
    input  logic  frag_valid_i,
    input  len_t  frag_len_i,
    input  port_t frag_dest_i,
    input  evid_t frag_evid_i,
    output logic  ready_o,
    output blk_t  blk_o
);

    logic  busy_q;
    port_t dest_q;
    len_t  rem_q;
    seq_t  seq_q;
    evid_t evid_q;

    logic  take;
    logic  fire;
    logic  fin;

    assign take = !busy_q && frag_valid_i && (frag_len_i != '0);
    assign fire = busy_q && launch_i && (dest_q == dest_for(SRC, int'(slot_i)));
    assign fin  = (rem_q <= len_t'(BLOCK_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            dest_q <= '0;
            rem_q  <= '0;
            seq_q  <= '0;
            evid_q <= '0;
            blk_o  <= '0;
        end else begin
            blk_o.valid <= 1'b0;
            if (take) begin
                busy_q <= 1'b1;
                dest_q <= frag_dest_i;
                rem_q  <= frag_len_i;
                seq_q  <= '0;
                evid_q <= frag_evid_i;
            end else if (fire) begin
                blk_o.valid    <= 1'b1;
                blk_o.dest     <= dest_q;
                blk_o.tag.evid <= evid_q;
                blk_o.tag.src  <= port_t'(SRC);
                blk_o.tag.seq  <= seq_q;
                blk_o.tag.last <= fin;
                blk_o.bytes    <= fin ? rem_q[BCW-1:0] : bcnt_t'(BLOCK_BYTES);
                rem_q          <= rem_q - len_t'(BLOCK_BYTES);
                seq_q          <= seq_q + 1'b1;
                if (fin) busy_q <= 1'b0;
            end
        end
    end

    assign ready_o = !busy_q;

    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ready_o && frag_valid_i && frag_len_i != '0) |=> !ready_o); // R9

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        (ready_o && frag_valid_i && frag_len_i == '0) |=> ready_o); // R10

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !launch_i) |=> !ready_o); // R9

endmodule

// File: rtl/bsh_top.sv
module bsh_top
    import bsh_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NP-1:0]             frag_valid_i,
    input  logic [NP-1:0][LENW-1:0]   frag_len_i,
    input  logic [NP-1:0][PW-1:0]     frag_dest_i,
    input  logic [NP-1:0][EVW-1:0]    frag_evid_i,
    output logic [NP-1:0]             frag_ready_o,
    output logic [NP-1:0]             blk_valid_o,
    output logic [NP-1:0][PW-1:0]     blk_dest_o,
    output logic [NP-1:0][EVW-1:0]    blk_evid_o,
    output logic [NP-1:0][PW-1:0]     blk_src_o,
    output logic [NP-1:0][SEQW-1:0]   blk_seq_o,
    output logic [NP-1:0]             blk_last_o,
    output logic [NP-1:0][BCW-1:0]    blk_bytes_o,
    output logic [PW-1:0]             slot_o
);

    cyc_t  cyc;
    port_t slot;
    logic  launch;
    blk_t  blk [NP];

    bsh_slot_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .cyc_o    (cyc),
        .slot_o   (slot),
        .launch_o (launch)
    );

    assign slot_o = slot;

    for (genvar i = 0; i < NP; i++) begin : g_lane
        bsh_lane #(.SRC(i)) u_lane (
            .clk          (clk),
            .rst          (rst),
            .launch_i     (launch),
            .slot_i       (slot),
            .frag_valid_i (frag_valid_i[i]),
            .frag_len_i   (frag_len_i[i]),
            .frag_dest_i  (frag_dest_i[i]),
            .frag_evid_i  (frag_evid_i[i]),
            .ready_o      (frag_ready_o[i]),
            .blk_o        (blk[i])
        );

        assign blk_valid_o[i] = blk[i].valid;
        assign blk_dest_o[i]  = blk[i].dest;
        assign blk_evid_o[i]  = blk[i].tag.evid;
        assign blk_src_o[i]   = blk[i].tag.src;
        assign blk_seq_o[i]   = blk[i].tag.seq;
        assign blk_last_o[i]  = blk[i].tag.last;
        assign blk_bytes_o[i] = blk[i].bytes;

        AST_ROUTE: assert property (@(posedge clk) disable iff (rst)
            blk_valid_o[i] |-> (blk_dest_o[i] == dest_for(i, int'(slot)))); // R3

        AST_PAD_FULL: assert property (@(posedge clk) disable iff (rst)
            (blk_valid_o[i] && !blk_last_o[i]) |-> (blk_bytes_o[i] == bcnt_t'(BLOCK_BYTES))); // R6

        AST_LAST_BYTES: assert property (@(posedge clk) disable iff (rst)
            (blk_valid_o[i] && blk_last_o[i]) |-> (blk_bytes_o[i] != '0)); // R6

        AST_LAST_READY: assert property (@(posedge clk) disable iff (rst)
            (blk_valid_o[i] && blk_last_o[i]) |-> frag_ready_o[i]); // R9
    end

    logic [NP-1:0][NP-1:0] hit;

    for (genvar d = 0; d < NP; d++) begin : g_dest
        for (genvar i = 0; i < NP; i++) begin : g_src
            assign hit[d][i] = blk_valid_o[i] && (blk_dest_o[i] == port_t'(d));
        end

        AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (rst)
            $onehot0(hit[d])); // R4
    end

    AST_PHASE: assert property (@(posedge clk) disable iff (rst)
        (|blk_valid_o) |-> (cyc == cyc_t'(PHASE1))); // R2

endmodule

// File: tb/tb_bsh_top.sv
`timescale 1ns/1ps
module tb_bsh_top;
    import bsh_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [NP-1:0]           frag_valid = '0;
    logic [NP-1:0][LENW-1:0] frag_len = '0;
    logic [NP-1:0][PW-1:0]   frag_dest = '0;
    logic [NP-1:0][EVW-1:0]  frag_evid = '0;
    logic [NP-1:0]           frag_ready;
    logic [NP-1:0]           blk_valid;
    logic [NP-1:0][PW-1:0]   blk_dest;
    logic [NP-1:0][EVW-1:0]  blk_evid;
    logic [NP-1:0][PW-1:0]   blk_src;
    logic [NP-1:0][SEQW-1:0] blk_seq;
    logic [NP-1:0]           blk_last;
    logic [NP-1:0][BCW-1:0]  blk_bytes;
    logic [PW-1:0]           slot;

    bsh_top dut (
        .clk          (clk),
        .rst          (rst),
        .frag_valid_i (frag_valid),
        .frag_len_i   (frag_len),
        .frag_dest_i  (frag_dest),
        .frag_evid_i  (frag_evid),
        .frag_ready_o (frag_ready),
        .blk_valid_o  (blk_valid),
        .blk_dest_o   (blk_dest),
        .blk_evid_o   (blk_evid),
        .blk_src_o    (blk_src),
        .blk_seq_o    (blk_seq),
        .blk_last_o   (blk_last),
        .blk_bytes_o  (blk_bytes),
        .slot_o       (slot)
    );

    always #2.5 clk = ~clk;

    int   total = 0;
    int   bad   = 0;
    int   cnt   = 0;
    logic done  = 1'b0;
    blk_t exp_q [NP][$];
    int   prev_abs [NP];

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) if (!rst) cnt <= cnt + 1;

    // monitor: pops expected blocks and compares
    always @(negedge clk) begin
        if (!rst) begin
            logic [NP-1:0] seen;
            int abs_slot;
            seen = '0;
            abs_slot = cnt / SLOT_CYC;
            if (cnt % SLOT_CYC == 0)
                chk(int'(slot) == abs_slot % NP, "R2 slot index", int'(slot), abs_slot % NP);
            for (int i = 0; i < NP; i++) begin
                if (blk_valid[i]) begin
                    blk_t e;
                    chk(cnt % SLOT_CYC == PHASE1, "R2 block phase", cnt % SLOT_CYC, PHASE1);
                    chk(int'(slot) == abs_slot % NP, "R2 slot at block", int'(slot), abs_slot % NP);
                    chk(int'(blk_dest[i]) == (i + abs_slot) % NP, "R3 rotation dest",
                        int'(blk_dest[i]), (i + abs_slot) % NP);
                    chk(!seen[blk_dest[i]], "R4 dest collision", int'(blk_dest[i]), -1);
                    seen[blk_dest[i]] = 1'b1;
                    if (exp_q[i].size() == 0) begin
                        chk(1'b0, "R5 unexpected block", i, -1);
                    end else begin
                        e = exp_q[i].pop_front();
                        chk(blk_dest[i] == e.dest, "R5 block dest", int'(blk_dest[i]), int'(e.dest));
                        chk(blk_seq[i] == e.tag.seq, "R5 sequence", int'(blk_seq[i]), int'(e.tag.seq));
                        chk(blk_last[i] == e.tag.last, "R6 final flag", int'(blk_last[i]), int'(e.tag.last));
                        chk(blk_bytes[i] == e.bytes, "R6 byte count", int'(blk_bytes[i]), int'(e.bytes));
                        chk(blk_evid[i] == e.tag.evid, "R7 event id", int'(blk_evid[i]), int'(e.tag.evid));
                        chk(int'(blk_src[i]) == i, "R7 source id", int'(blk_src[i]), i);
                        if (e.tag.seq != '0)
                            chk(abs_slot == prev_abs[i] + NP, "R8 rotation spacing",
                                abs_slot - prev_abs[i], NP);
                        prev_abs[i] = abs_slot;
                    end
                    if (blk_last[i])
                        chk(frag_ready[i], "R9 ready after final", int'(frag_ready[i]), 1);
                end
            end
        end
    end

    task automatic load(input int s, input int d, input int len, input int ev);
        int nb;
        while (!frag_ready[s]) @(negedge clk);
        frag_valid[s] = 1'b1;
        frag_len[s]   = len_t'(len);
        frag_dest[s]  = port_t'(d);
        frag_evid[s]  = evid_t'(ev);
        nb = (len + BLOCK_BYTES - 1) / BLOCK_BYTES;
        for (int j = 0; j < nb; j++) begin
            blk_t b;
            b.valid    = 1'b1;
            b.dest     = port_t'(d);
            b.tag.evid = evid_t'(ev);
            b.tag.src  = port_t'(s);
            b.tag.seq  = seq_t'(j);
            b.tag.last = (j == nb - 1);
            b.bytes    = (j == nb - 1) ? bcnt_t'(len - j * BLOCK_BYTES) : bcnt_t'(BLOCK_BYTES);
            exp_q[s].push_back(b);
        end
        @(negedge clk);
        frag_valid[s] = 1'b0;
        chk(!frag_ready[s], "R9 ready drops on load", int'(frag_ready[s]), 0);
    endtask

    task automatic drain();
        int left;
        for (int c = 0; c < 4000; c++) begin
            left = 0;
            for (int i = 0; i < NP; i++) left += exp_q[i].size();
            if (left == 0) break;
            @(negedge clk);
        end
        repeat (SLOT_CYC) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NP; i++) prev_abs[i] = 0;
        repeat (3) @(negedge clk);
        chk(frag_ready == '1, "R1 ready in reset", int'(frag_ready), (1 << NP) - 1);
        chk(blk_valid == '0, "R1 no block in reset", int'(blk_valid), 0);
        chk(slot == '0, "R1 slot in reset", int'(slot), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(frag_ready == '1, "R1 ready after reset", int'(frag_ready), (1 << NP) - 1);

        // single fragment with a short remainder
        load(0, 3, 200, 8'h11);
        drain();

        // every source busy at once, mixed lengths and destinations
        load(0, 5, 128, 8'h20);
        load(1, 1, 1,   8'h21);
        load(2, 7, 64,  8'h22);
        load(3, 3, 300, 8'h23);
        load(4, 0, 65,  8'h24);
        load(5, 5, 190, 8'h25);
        load(6, 2, 250, 8'h26);
        load(7, 6, 33,  8'h27);
        drain();

        // request while busy is ignored (R9)
        load(2, 4, 300, 8'h30);
        frag_valid[2] = 1'b1;
        frag_len[2]   = len_t'(64);
        frag_dest[2]  = port_t'(1);
        frag_evid[2]  = 8'hEE;
        @(negedge clk);
        frag_valid[2] = 1'b0;
        chk(!frag_ready[2], "R9 busy request ignored", int'(frag_ready[2]), 0);

        // zero-length request is ignored (R10)
        while (!frag_ready[5]) @(negedge clk);
        frag_valid[5] = 1'b1;
        frag_len[5]   = '0;
        frag_dest[5]  = port_t'(2);
        frag_evid[5]  = 8'h55;
        @(negedge clk);
        frag_valid[5] = 1'b0;
        chk(frag_ready[5], "R10 zero length keeps ready", int'(frag_ready[5]), 1);
        drain();
        repeat (NP * SLOT_CYC) @(negedge clk);

        for (int i = 0; i < NP; i++)
            chk(exp_q[i].size() == 0, "R5 all blocks delivered", exp_q[i].size(), 0);
        chk(frag_ready == '1, "R10 ready idle at end", int'(frag_ready), (1 << NP) - 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule